// File: doc/BRIEF.md
# Pin Controller with Sticky Edge Capture

This block drives and observes one general-purpose pin through a single 16-bit control word. Software sets the output value and the output-enable of the pin driver, and reads back the state of the pin in one input bit. A mode bit gives that input bit one of two meanings. In level mode it is a live, synchronized sample of the pin. In edge mode it is a sticky flag that any rising or falling transition of the pin sets. The flag stays set until software writes the clear bit.

The pin input passes through a two-flop synchronizer before either use, so the pin may be fully asynchronous to the clock. A write that asks for a clear in the same cycle as a freshly detected edge loses to the edge, so no transition is ever dropped. The clear bit clears itself: it reads 1 for the one cycle after it was written and then reads 0. The read port is registered.

Top module: `gpio_edge_pin`

## Requirements
- R1: After a synchronous active-high reset, `rd_data`, `pin_out` and `pin_oe` are all 0, level mode is selected and the input bit is 0.
- R2: A write sets the output value from `wr_data` bit 5 onto `pin_out` and the driver enable from bit 4 onto `pin_oe`, one clock after the write edge; `pin_oe` = 0 means the pin is tri-stated.
- R3: With mode bit 6 = 0 (level mode), read bit 3 follows the pin level; a pin change set up before clock edge A is visible on `rd_data` bit 3 after edge A+3 and not before.
- R4: With mode bit 6 = 1 (edge mode), a rising or a falling pin transition sets the input bit to 1, and it stays 1 while no clear is requested, whatever the pin does.
- R5: Writing 1 to bit 2 forces the input bit to 0; writing 0 to bit 2 leaves it unchanged; bit 2 reads 1 in the read cycle after the write and 0 after that.
- R6: In edge mode, when a detected edge and a clear request fall on the same clock edge, the input bit ends up 1.
- R7: Bits 15 to 7 of `rd_data` always read 0, and writes to bit 3 have no effect on the input bit.
- R8: `rd_data` is a register: it shows the control state as of the previous clock edge, so a write is visible on `rd_data` two edges after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Registered read-back of the control word |
| pin_in | input | 1 | Asynchronous pin level from the pad |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Driver enable; 0 tri-states the pin |

## Verification
The hardest case to reach from the ports is the collision of a clear request with an edge on the very same clock edge, because the edge first travels through two synchronizer flops and the edge register. The bench changes the pin before a known edge A, counts two edges, and drives the clear write so that it is sampled on edge A+2, the edge where the detector fires. Random rounds then feed short random pin sequences, one level per cycle, so that single-cycle pulses and back-to-back transitions are also seen by the detector.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int REG_W    = 16;
  localparam int BIT_MODE = 6;
  localparam int BIT_OUT  = 5;
  localparam int BIT_OE   = 4;
  localparam int BIT_IN   = 3;
  localparam int BIT_CLR  = 2;
  localparam int USED_TOP = BIT_MODE;

  typedef struct packed {
    logic edge_mode;
    logic out_val;
    logic out_en;
    logic in_flag;
    logic clr_pend;
  } pin_ctrl_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[LAST];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic edge_hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  // both directions count
  assign edge_hit = prev_q ^ level;
endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
  import gpio_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pin_level,
  input  logic             edge_hit,
  output pin_ctrl_t        state
);
  logic clr_req;

  always_comb clr_req = wr_en & wr_data[BIT_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else begin
      if (wr_en) begin
        state.edge_mode <= wr_data[BIT_MODE];
        state.out_val   <= wr_data[BIT_OUT];
        state.out_en    <= wr_data[BIT_OE];
      end
      state.clr_pend <= clr_req;
      if (state.edge_mode) begin
        if (edge_hit)     state.in_flag <= 1'b1;
        else if (clr_req) state.in_flag <= 1'b0;
      end else begin
        state.in_flag <= pin_level & ~clr_req;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_pin.sv
module gpio_edge_pin
  import gpio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe
);
  logic      pin_sync;
  logic      edge_hit;
  pin_ctrl_t state;
  logic      flag_q;
  logic      mode_q;
  logic [REG_W-1:0] rd_next;

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_edge_det u_edge (
    .clk(clk), .rst(rst), .level(pin_sync), .edge_hit(edge_hit)
  );

  gpio_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pin_level(pin_sync), .edge_hit(edge_hit), .state(state)
  );

  assign flag_q  = state.in_flag;
  assign mode_q  = state.edge_mode;
  assign pin_out = state.out_val;
  assign pin_oe  = state.out_en;

  always_comb begin
    rd_next           = '0;
    rd_next[BIT_MODE] = state.edge_mode;
    rd_next[BIT_OUT]  = state.out_val;
    rd_next[BIT_OE]   = state.out_en;
    rd_next[BIT_IN]   = state.in_flag;
    rd_next[BIT_CLR]  = state.clr_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_edge_pin_chk.sv
module gpio_edge_pin_chk
  import gpio_edge_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             pin_oe,
  input logic             pin_out,
  input logic             flag_q,
  input logic             mode_q,
  input logic             edge_hit,
  input logic             pin_sync
);
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:USED_TOP+1] == '0);

  // R2
  drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pin_oe == $past(wr_data[BIT_OE])) && (pin_out == $past(wr_data[BIT_OUT])));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && flag_q && !(wr_en && wr_data[BIT_CLR])) |=> flag_q);

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && edge_hit) |=> flag_q);

  // R5
  clear_acts_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !edge_hit && wr_en && wr_data[BIT_CLR]) |=> !flag_q);

  // R3
  level_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !(wr_en && wr_data[BIT_CLR])) |=> (flag_q == $past(pin_sync)));
endmodule

bind gpio_edge_pin gpio_edge_pin_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pin_oe(pin_oe), .pin_out(pin_out), .flag_q(flag_q), .mode_q(mode_q),
  .edge_hit(edge_hit), .pin_sync(pin_sync)
);

// File: tb/gpio_edge_pin_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_pin_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_pin dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic any_change(input logic start, input logic [7:0] seq, input int len);
    logic prev = start;
    logic hit = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (seq[i] != prev) hit = 1'b1;
      prev = seq[i];
    end
    return hit;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    ticks(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0000);
    chk("R1 pin_oe", {15'd0, pin_oe}, 16'd0);
    chk("R1 pin_out", {15'd0, pin_out}, 16'd0);

    // R2 / R8 drive bits
    wr(16'h0030);
    chk("R2 pin_out high", {15'd0, pin_out}, 16'd1);
    chk("R2 pin_oe on", {15'd0, pin_oe}, 16'd1);
    ticks(1);
    chk("R8 rd after write", rd_data, 16'h0030);
    wr(16'h0010);
    chk("R2 pin_out low", {15'd0, pin_out}, 16'd0);
    wr(16'h0000);
    chk("R2 tri-state", {15'd0, pin_oe}, 16'd0);

    // R7 upper bits, R5 clear self-clears
    wr(16'hFFFF);
    ticks(0);
    chk("R7 R5 full write readback", rd_data, 16'h0074);
    ticks(1);
    chk("R5 clear bit self-clears", rd_data, 16'h0070);

    // R3 level mode latency
    wr(16'h0000);
    ticks(3);
    pin_in = 1'b1;
    ticks(3);
    chk("R3 not yet visible", {15'd0, rd_data[3]}, 16'd0);
    ticks(1);
    chk("R3 level high", {15'd0, rd_data[3]}, 16'd1);
    pin_in = 1'b0;
    ticks(4);
    chk("R3 level low", {15'd0, rd_data[3]}, 16'd0);
    // R7 write to bit 3 ignored
    wr(16'h0008);
    ticks(2);
    chk("R7 bit3 write ignored", {15'd0, rd_data[3]}, 16'd0);

    // R4 edge mode
    wr(16'h0044);
    ticks(4);
    chk("R4 start clear", {15'd0, rd_data[3]}, 16'd0);
    pin_in = 1'b1;
    ticks(4);
    chk("R4 rising sets", {15'd0, rd_data[3]}, 16'd1);
    ticks(6);
    chk("R4 sticky", {15'd0, rd_data[3]}, 16'd1);
    wr(16'h0040);
    ticks(2);
    chk("R5 zero clear no effect", {15'd0, rd_data[3]}, 16'd0001);
    wr(16'h0044);
    ticks(2);
    chk("R5 clear works", {15'd0, rd_data[3]}, 16'd0);
    pin_in = 1'b0;
    ticks(4);
    chk("R4 falling sets", {15'd0, rd_data[3]}, 16'd1);
    wr(16'h0044);
    ticks(5);
    chk("R5 cleared again", {15'd0, rd_data[3]}, 16'd0);

    // R6 collision: pin change before edge A, clear sampled at A+2
    pin_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h0044;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    ticks(3);
    chk("R6 edge beats clear", {15'd0, rd_data[3]}, 16'd1);

    // random rounds
    for (int r = 0; r < 60; r++) begin
      if (r % 2 == 0) begin
        logic start;
        logic [7:0] seq;
        int len;
        start = pin_in;
        seq = 8'($urandom);
        len = 1 + int'($urandom % 8);
        wr(16'h0044);
        ticks(5);
        for (int i = 0; i < len; i++) begin
          pin_in = seq[i];
          @(negedge clk);
        end
        ticks(5);
        chk("R4 random edge flag", {15'd0, rd_data[3]}, {15'd0, any_change(start, seq, len)});
      end else begin
        logic lv;
        logic [15:0] wd;
        wd = 16'($urandom) & 16'hFFB0;
        wr(wd);
        lv = 1'($urandom);
        pin_in = lv;
        ticks(4);
        chk("R3 random level", rd_data, {9'd0, 1'b0, wd[5:4], lv, 3'b000});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule